// File: doc/BRIEF.md
# Programmable Clock Divider with Half-Integer Ratio

This block derives a slower clock from a fast input clock. In its normal mode it divides by an integer ratio taken from a configuration input. When a mode bit is set, it instead divides by four and a half. In that mode the configured ratio is ignored, and output transitions fall on both rising and falling input edges.

The configuration inputs are not used directly. A copy of them is captured into an active configuration, and only while the synchronous reset is asserted. Software therefore writes a new ratio or mode, then pulses the reset, and the new setting takes effect when the reset is released.

No reset is needed after power-up: the active configuration and the counter start from their default values, and the output runs from the first clock edge. While the reset is asserted the output stays low. Counting restarts from the beginning of a period on the first rising input edge after release.

Top module: `clkdiv_top`

## Requirements
- R1: In integer mode the output period equals N input clock cycles, where N is the active ratio (for example 4 gives 40 ns and 5 gives 50 ns at a 10 ns input period).
- R2: In integer mode the output is high for floor(N/2) input cycles of each period, so an odd ratio is high for one cycle less than it is low.
- R3: An active ratio of 0 or 1 behaves exactly as a ratio of 2.
- R4: With the half mode bit set, every output period lasts 4.5 input cycles, with 2 cycles high and 2.5 cycles low, whatever value the ratio input holds.
- R5: Changes on `ratio_in` or `half_in` do not alter the output while reset is low. Their values are captured only on rising input edges at which `rst` is high.
- R6: Without any reset after power-up, the block divides by the default ratio DEF_RATIO (4 by default) in integer mode.
- R7: From the first rising input edge at which `rst` is sampled high, and for as long as it stays high, `clk_out` is low.
- R8: The first rising input edge at which `rst` is sampled low after a reset drives `clk_out` high; this starts the first period.
- R9: The largest ratio, 255, gives a 255-cycle period that is high for 127 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; both edges are used in half mode |
| rst | input | 1 | Synchronous active-high divider reset; also captures the configuration |
| ratio_in | input | 8 | Integer division ratio, captured during reset |
| half_in | input | 1 | Selects divide by 4.5 when 1, captured during reset |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench builds the block with its default parameters: an 8-bit ratio, a default ratio of 4 and integer mode at power-up. The 8-bit width brings the clamp values 0 and 1, the odd and even ratios and the top value 255 within reach, along with the power-up default run before any reset. The period and high time of each output clock are measured from edge timestamps, so the 2 and 2.5 cycle phases of half mode are resolved to the half cycle. Random ratios are mixed with occasional half-mode picks, and configuration writes made without a reset are checked to leave the output unchanged.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Width of the integer ratio field
    localparam int RATIO_W = 8;
    // Smallest integer ratio honoured; smaller requests are raised to it
    localparam int MIN_RATIO = 2;
    // Half mode: one counter sweep covers two output periods (9 input cycles)
    localparam int HALF_SWEEP = 9;
    // Half mode: cycles the output stays high per output period
    localparam int HALF_HIGH = 2;
    // Half mode: counter value at which the second (falling-edge) pulse is requested
    localparam int HALF_LATE_AT = 4;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic   half;
        ratio_t ratio;
    } div_cfg_t;

    // Pulse requests produced in the rising-edge domain
    typedef struct packed {
        logic early;   // high window aligned to rising edges
        logic late;    // window to be retimed onto falling edges
    } phase_req_t;

    // Number of counter states in one sweep
    function automatic ratio_t sweep_len(input div_cfg_t c);
        ratio_t r;
        if (c.half) begin
            r = ratio_t'(HALF_SWEEP);
        end else if (c.ratio < ratio_t'(MIN_RATIO)) begin
            r = ratio_t'(MIN_RATIO);
        end else begin
            r = c.ratio;
        end
        return r;
    endfunction

    // Length of the rising-edge-aligned high window
    function automatic ratio_t early_len(input div_cfg_t c);
        ratio_t r;
        if (c.half) begin
            r = ratio_t'(HALF_HIGH);
        end else begin
            r = sweep_len(c) >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_hold.sv
module clkdiv_cfg_hold
    import clkdiv_pkg::*;
#(
    parameter div_cfg_t DEF_CFG = '{half: 1'b0, ratio: ratio_t'(4)}
) (
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg_in,
    output div_cfg_t cfg_act
);

    // Power-up value lets the divider run without any reset
    div_cfg_t act_q = DEF_CFG;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= cfg_in;
        end
    end

    assign cfg_act = act_q;

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  div_cfg_t   cfg_act,
    output ratio_t     cnt,
    output ratio_t     period,
    output phase_req_t req,
    output logic       hold
);

    ratio_t     cnt_q  = '0;
    phase_req_t req_q  = '0;
    logic       hold_q = 1'b0;

    ratio_t     len_w;
    ratio_t     hi_w;
    logic       wrap_w;
    phase_req_t req_d;

    always_comb begin
        len_w  = sweep_len(cfg_act);
        hi_w   = early_len(cfg_act);
        wrap_w = (cnt_q == len_w - ratio_t'(1));
        req_d.early = (cnt_q < hi_w);
        req_d.late  = cfg_act.half
                   && (cnt_q >= ratio_t'(HALF_LATE_AT))
                   && (cnt_q <  ratio_t'(HALF_LATE_AT + HALF_HIGH));
    end

    // cnt_q names the cycle that begins at the next rising edge
    always_ff @(posedge clk) begin
        hold_q <= rst;
        if (rst) begin
            cnt_q <= '0;
            req_q <= '0;
        end else begin
            req_q <= req_d;
            cnt_q <= wrap_w ? '0 : cnt_q + ratio_t'(1);
        end
    end

    assign cnt    = cnt_q;
    assign period = len_w;
    assign req    = req_q;
    assign hold   = hold_q;

endmodule

// File: rtl/clkdiv_merge.sv
module clkdiv_merge
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       hold,
    input  phase_req_t req,
    output logic       clk_out
);

    // Late window shifted by half an input cycle
    logic late_n = 1'b0;

    always_ff @(negedge clk) begin
        late_n <= req.late;
    end

    assign clk_out = req.early | (late_n & ~hold);

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int   DEF_RATIO = 4,
    parameter logic DEF_HALF  = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               half_in,
    output logic               clk_out
);

    localparam div_cfg_t DEF_CFG = '{half: DEF_HALF, ratio: ratio_t'(DEF_RATIO)};

    div_cfg_t   cfg_req;
    div_cfg_t   cfg_act;
    ratio_t     cnt;
    ratio_t     period;
    phase_req_t req;
    logic       hold;

    assign cfg_req = '{half: half_in, ratio: ratio_in};

    clkdiv_cfg_hold #(.DEF_CFG(DEF_CFG)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_in  (cfg_req),
        .cfg_act (cfg_act)
    );

    clkdiv_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .cfg_act (cfg_act),
        .cnt     (cnt),
        .period  (period),
        .req     (req),
        .hold    (hold)
    );

    clkdiv_merge u_merge (
        .clk     (clk),
        .hold    (hold),
        .req     (req),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
    import clkdiv_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     clk_out,
    input div_cfg_t cfg_act,
    input ratio_t   cnt,
    input ratio_t   period
);

    // R7
    reset_low_chk: assert property (@(posedge clk) rst |=> !clk_out);

    // R8
    release_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(rst)) |=> clk_out);

    // R5
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_act));

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < period);

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == period - ratio_t'(1)) |=> (cnt == '0));

    // R4
    half_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_act.half && clk_out && $past(clk_out)) |-> !$past(clk_out, 2));

endmodule

bind clkdiv_top clkdiv_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_out (clk_out),
    .cfg_act (cfg_act),
    .cnt     (cnt),
    .period  (period)
);

// File: tb/clkdiv_top_tb.sv
`timescale 1ns/1ps
module clkdiv_top_tb;

    localparam real TCLK = 10.0;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [7:0] ratio_in = 8'd4;
    logic       half_in = 1'b0;
    logic       clk_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    clkdiv_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .ratio_in (ratio_in),
        .half_in  (half_in),
        .clk_out  (clk_out)
    );

    function automatic real exp_period(input int r, input bit h);
        int n;
        if (h) return 4.5 * TCLK;
        n = (r < 2) ? 2 : r;
        return n * TCLK;
    endfunction

    function automatic real exp_high(input int r, input bit h);
        int n;
        if (h) return 2.0 * TCLK;
        n = (r < 2) ? 2 : r;
        return (n / 2) * TCLK;
    endfunction

    task automatic check_real(input string req, input real act, input real expv);
        total++;
        if (act < expv - 0.01 || act > expv + 0.01) begin
            bad++;
            $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, expv);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic measure(output real per, output real hi);
        real t0, t1, t2;
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    task automatic check_run(input string req, input int r, input bit h, input int n);
        real per, hi;
        for (int i = 0; i < n; i++) begin
            measure(per, hi);
            check_real({req, " period"}, per, exp_period(r, h));
            check_real({req, " high"}, hi, exp_high(r, h));
        end
    endtask

    // Writes the configuration, pulses reset, checks the first rise (R8)
    task automatic load(input int r, input bit h);
        real t;
        @(negedge clk);
        ratio_in = 8'(r);
        half_in  = h;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t = $realtime;
        @(posedge clk_out);
        check_real("R8 first rise delay", $realtime - t, TCLK / 2.0);
    endtask

    initial begin
        #(200000 * TCLK);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r;
        bit h;
        void'($urandom(32'd1234));

        // R6: power-up default, no reset
        check_run("R6 default", 4, 1'b0, 2);

        // R1 R2: even and odd ratios
        load(4, 1'b0); check_run("R1 R2 ratio4", 4, 1'b0, 2);
        load(5, 1'b0); check_run("R1 R2 ratio5", 5, 1'b0, 2);
        load(2, 1'b0); check_run("R1 ratio2", 2, 1'b0, 2);

        // R3: clamp
        load(0, 1'b0); check_run("R3 ratio0", 0, 1'b0, 2);
        load(1, 1'b0); check_run("R3 ratio1", 1, 1'b0, 2);

        // R4: half mode, ratio ignored
        load(7, 1'b1); check_run("R4 half ratio7", 7, 1'b1, 4);
        load(0, 1'b1); check_run("R4 half ratio0", 0, 1'b1, 4);

        // R9: largest ratio
        load(255, 1'b0); check_run("R9 ratio255", 255, 1'b0, 1);

        // R5: inputs changed without reset have no effect
        load(6, 1'b0);
        @(negedge clk);
        ratio_in = 8'd11;
        half_in  = 1'b1;
        check_run("R5 no reset", 6, 1'b0, 2);
        @(negedge clk);
        ratio_in = 8'd3;
        half_in  = 1'b0;
        check_run("R5 no reset again", 6, 1'b0, 1);
        load(3, 1'b0); check_run("R5 after reset", 3, 1'b0, 1);

        // R7: output low while reset held, including mid-window in half mode
        load(9, 1'b1);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check_bit("R7 low in reset", clk_out, 1'b0);
            @(posedge clk); #1;
            check_bit("R7 low in reset", clk_out, 1'b0);
        end
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk_out);
        check_run("R4 after long reset", 9, 1'b1, 2);

        // Random mix (R1 R2 R3 R4)
        for (int k = 0; k < 20; k++) begin
            r = int'($urandom_range(0, 40));
            h = ($urandom_range(0, 7) == 0);
            load(r, h);
            check_run("R1 R2 R4 random", r, h, 2);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule